// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is one timer channel behind a small word-addressed register bus. Software loads a start count, picks a tick source and a mode in a control word, and sets the run bit. While running, the counter drops by one on every clock cycle in which the selected tick-enable input is high. When a step is taken from zero, the channel raises a sticky interrupt. The counter then either restarts from the stored start count (periodic mode) or rolls over to its all-ones maximum (free-run mode).

The two tick-enable inputs come from prescalers outside the block: one fast rate and one slower alternate. A write of any data to the clear word drops the interrupt. The usual reprogramming sequence has three steps. Software first writes the control word with the run bit clear. It then writes the start count, which a stopped channel also copies straight into the counter. Last, it writes the control word again with the run bit set. The counter width is a parameter, and reads return the count zero-extended to 32 bits.

Top module: `ivt_channel`

## Requirements
- R1: After reset the start-count word, the count, the control word and the interrupt output all read zero.
- R2: The control word at offset 0x08 stores bit 7 (run), bit 6 (periodic) and bit 3 (fast tick select). It reads back only those three bits; every other bit reads zero.
- R3: A write to offset 0x00 stores the low CNT_W bits as the start count, which reads back at 0x00. If run is clear, the same write also copies the value into the counter, readable at offset 0x04.
- R4: While run is set, the counter drops by exactly one on each cycle in which the selected tick input is high. While run is clear, it holds its value whatever the ticks do.
- R5: With bit 3 set, the counter follows tick_fast and ignores tick_slow. With bit 3 clear, it follows tick_slow and ignores tick_fast.
- R6: In periodic mode, a step taken at count zero reloads the counter with the start count.
- R7: In free-run mode (bit 6 clear), a step taken at count zero sets the counter to all ones.
- R8: A step taken at count zero sets irq on the same clock edge. irq then stays set through later steps until it is cleared.
- R9: A write of any data to offset 0x0C clears irq. If a step from zero happens in the same cycle, irq stays set. The clear word reads zero.
- R10: Writes to offset 0x04 have no effect. A write to 0x00 while run is set changes only the start count, not the counter.
- R11: Reads of 0x00 and 0x04 return the CNT_W-bit value zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fast | input | 1 | Fast tick enable, used when control bit 3 is set |
| tick_slow | input | 1 | Slow tick enable, used when control bit 3 is clear |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Byte offset of the word being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Sticky underflow interrupt |

## Verification
Bursts on the selected tick and then on the unselected tick are set against each other; this separates correct source selection from a swapped or merged selection. Runs that cross zero are made in both modes, so a reload from the start count can be told apart from a rollover to all ones. The bench also drives a clear write in the same cycle as a step from zero, which shows whether the underflow takes priority over the clear. Writes to the count word, and start-count writes made while the timer is running, show that the counter is preset only while the channel is stopped.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_START = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 4'hC;

  localparam int BIT_RUN  = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_FAST = 3;

  typedef struct packed {
    logic run;
    logic periodic;
    logic fast;
  } ivt_ctrl_t;

  function automatic ivt_ctrl_t word_to_ctrl(input logic [BUS_W-1:0] w);
    ivt_ctrl_t c;
    c.run      = w[BIT_RUN];
    c.periodic = w[BIT_PER];
    c.fast     = w[BIT_FAST];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_to_word(input ivt_ctrl_t c);
    logic [BUS_W-1:0] w;
    w           = '0;
    w[BIT_RUN]  = c.run;
    w[BIT_PER]  = c.periodic;
    w[BIT_FAST] = c.fast;
    return w;
  endfunction
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output ivt_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  start_q,
  output logic              start_wr,
  output logic              clr_wr,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic ctrl_wr;

  assign start_wr = bus_wr && (bus_addr == OFS_START);
  assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
  assign clr_wr   = bus_wr && (bus_addr == OFS_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      start_q <= '0;
    end else begin
      if (ctrl_wr)  ctrl    <= word_to_ctrl(bus_wdata);
      if (start_wr) start_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_START: bus_rdata = BUS_W'(start_q);
      OFS_COUNT: bus_rdata = BUS_W'(cnt);
      OFS_CTRL:  bus_rdata = ctrl_to_word(ctrl);
      default:   bus_rdata = '0;
    endcase
  end

  generate
    if (CNT_W < BUS_W) begin : g_narrow
      logic unused_high;
      assign unused_high = ^bus_wdata[BUS_W-1:CNT_W];
    end
  endgenerate
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ivt_ctrl_t        ctrl,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             preset,
  input  logic [CNT_W-1:0] preset_val,
  input  logic [CNT_W-1:0] start_q,
  output logic             step,
  output logic             underflow,
  output logic [CNT_W-1:0] cnt
);
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic             periodic,
    input logic [CNT_W-1:0] start
  );
    if (cur == '0) return periodic ? start : '1;
    return cur - 1'b1;
  endfunction

  logic tick_sel;

  assign tick_sel  = ctrl.fast ? tick_fast : tick_slow;
  assign step      = ctrl.run && tick_sel;
  assign underflow = step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (preset) cnt <= preset_val;
    else if (step)   cnt <= next_count(cnt, ctrl.periodic, start_q);
  end
endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic underflow,
  input  logic clr_wr,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq <= 1'b0;
    else if (underflow) irq <= 1'b1;
    else if (clr_wr)    irq <= 1'b0;
  end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  ivt_ctrl_t        ctrl;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] cnt;
  logic             start_wr;
  logic             clr_wr;
  logic             preset;
  logic             step;
  logic             underflow;

  assign preset = start_wr && !ctrl.run;

  ivt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt),
    .ctrl      (ctrl),
    .start_q   (start_q),
    .start_wr  (start_wr),
    .clr_wr    (clr_wr),
    .bus_rdata (bus_rdata)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .tick_fast  (tick_fast),
    .tick_slow  (tick_slow),
    .preset     (preset),
    .preset_val (bus_wdata[CNT_W-1:0]),
    .start_q    (start_q),
    .step       (step),
    .underflow  (underflow),
    .cnt        (cnt)
  );

  ivt_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .underflow (underflow),
    .clr_wr    (clr_wr),
    .irq       (irq)
  );
endmodule

// File: rtl/ivt_channel_chk.sv
module ivt_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             run,
  input logic             periodic,
  input logic             step,
  input logic             underflow,
  input logic             clr_wr,
  input logic             start_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] start_q
);
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_wr |=> irq); // R8
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && !underflow |=> !irq); // R9
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && periodic |=> cnt == $past(start_q)); // R6
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !periodic |=> cnt == {CNT_W{1'b1}}); // R7
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    step && (cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1)); // R4
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !start_wr |=> $stable(cnt)); // R4
  AST_NO_STEP_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !step); // R4
endmodule

bind ivt_channel ivt_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .run       (ctrl.run),
  .periodic  (ctrl.periodic),
  .step      (step),
  .underflow (underflow),
  .clr_wr    (clr_wr),
  .start_wr  (start_wr),
  .cnt       (cnt),
  .start_q   (start_q)
);

// File: tb/test_ivt_channel.sv
module test_ivt_channel;
  localparam int W = 16;
  localparam logic [31:0] C_RUN = 32'h80, C_PER = 32'h40, C_FAST = 32'h08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ivt_channel #(.CNT_W(W)) i_ivt_channel (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input bit fast, input int n);
    @(negedge clk);
    if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
    repeat (n) @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); check("R1 start", d, 0);
    rd(4'h4, d); check("R1 count", d, 0);
    rd(4'h8, d); check("R1 ctrl", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); check("R2 ctrl readback", d, 32'hC8);
    wr(4'h8, 0);
    rd(4'h8, d); check("R2 ctrl cleared", d, 0);
  endtask

  task automatic t_preset();
    logic [31:0] d;
    wr(4'h0, 32'h0001_2345);
    rd(4'h0, d); check("R3 R11 start", d, 32'h2345);
    rd(4'h4, d); check("R3 R11 count preset", d, 32'h2345);
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(4'h8, C_RUN | C_PER | C_FAST);
    pulse(1, 5);
    rd(4'h4, d); check("R4 fast steps", d, 32'h2340);
    pulse(0, 3);
    rd(4'h4, d); check("R5 slow ignored", d, 32'h2340);
    wr(4'h8, C_PER | C_FAST);
    pulse(1, 3);
    rd(4'h4, d); check("R4 stopped hold", d, 32'h2340);
    wr(4'h8, C_RUN | C_PER);
    pulse(0, 4);
    rd(4'h4, d); check("R5 slow steps", d, 32'h233C);
    pulse(1, 4);
    rd(4'h4, d); check("R5 fast ignored", d, 32'h233C);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(4'h8, 0);
    wr(4'h0, 3);
    wr(4'h8, C_RUN | C_PER | C_FAST);
    pulse(1, 3);
    rd(4'h4, d); check("R6 at zero", d, 0);
    check("R8 no irq yet", {31'b0, irq}, 0);
    pulse(1, 1);
    rd(4'h4, d); check("R6 reload", d, 3);
    check("R8 irq set", {31'b0, irq}, 1);
    pulse(1, 2);
    rd(4'h4, d); check("R6 after reload", d, 1);
    check("R8 irq sticky", {31'b0, irq}, 1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(4'hC, 0);
    check("R9 cleared", {31'b0, irq}, 0);
    rd(4'hC, d); check("R9 clear reads zero", d, 0);
    pulse(1, 1);
    rd(4'h4, d); check("R9 setup zero", d, 0);
    @(negedge clk);
    tick_fast = 1'b1; bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 32'hDEAD;
    @(negedge clk);
    tick_fast = 1'b0; bus_wr = 1'b0;
    check("R9 underflow wins", {31'b0, irq}, 1);
    rd(4'h4, d); check("R6 reload on collide", d, 3);
  endtask

  task automatic t_freerun();
    logic [31:0] d;
    wr(4'h8, 0);
    wr(4'hC, 1);
    wr(4'h0, 1);
    wr(4'h8, C_RUN | C_FAST);
    pulse(1, 2);
    rd(4'h4, d); check("R7 R11 wrap", d, 32'h0000_FFFF);
    check("R8 irq free-run", {31'b0, irq}, 1);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(4'h4, 32'h55);
    rd(4'h4, d); check("R10 count write ignored", d, 32'hFFFF);
    wr(4'h0, 32'h10);
    rd(4'h4, d); check("R10 running start write", d, 32'hFFFF);
    rd(4'h0, d); check("R10 start updated", d, 32'h10);
    pulse(1, 1);
    rd(4'h4, d); check("R4 step after", d, 32'hFFFE);
    wr(4'h8, 0);
    pulse(1, 2);
    rd(4'h4, d); check("R4 stop hold", d, 32'hFFFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_preset();
    t_select();
    t_periodic();
    t_clear();
    t_freerun();
    t_ignored();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule